// File: doc/BRIEF.md
# Halfword Signed Multiply-Accumulate Long Unit

This execution unit carries out the 32-bit instruction group that multiplies two signed 16-bit halves and adds the product into a 64-bit accumulator held as a pair of registers. Each cycle it can accept one instruction word together with a condition-pass flag, the two 32-bit source operands, and the current accumulator as a high word and a low word. The unit decodes the instruction word, picks the upper or lower half of each source, and multiplies the two halves as signed values. It sign-extends the 32-bit product and adds it to the accumulator.

One register stage later, the unit returns the new high and low words, the register index for each of them, and a write enable for each. The register file, condition evaluation and the other multiply forms are outside this unit. The addition wraps silently, and the unit produces no flag outputs.

Top module: `hmacl_unit`

## Requirements
- R1: Instruction bit 5 selects the source-N operand half: 1 takes bits [31:16] and 0 takes bits [15:0]. Instruction bit 6 makes the same choice for the source-M operand. Together these two bits give the four forms (bottom/bottom, top/bottom, bottom/top, top/top).
- R2: The two selected halves are multiplied as signed two's-complement 16-bit values, giving a signed 32-bit product.
- R3: The product is sign-extended to 64 bits and added to {acc_hi, acc_lo}. Sum bits [63:32] appear on res_hi and sum bits [31:0] appear on res_lo.
- R4: The 64-bit addition wraps modulo 2^64, and no overflow indication exists.
- R5: An instruction word is recognised only when bits [27:20] equal 8'h14, bit 7 is 1 and bit 4 is 0. For any other word, dec_ok is low and neither write enable is raised.
- R6: When cond_pass is low, neither write enable is raised, so both destination registers keep their values.
- R7: Results appear exactly one cycle after the input: res_valid is in_valid delayed by one clock. A synchronous active-high reset clears res_valid and both write enables.
- R8: The high-word destination index is instruction bits [19:16], and the low-word destination index is instruction bits [15:12].
- R9: When the two destination indices are equal, only the high-word write is enabled.
- R10: The unselected half of each source operand has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input bundle is valid this cycle |
| instr | input | 32 | Instruction word |
| cond_pass | input | 1 | Condition check passed for this instruction |
| src_n | input | 32 | First source operand |
| src_m | input | 32 | Second source operand |
| acc_hi | input | 32 | Accumulator high word |
| acc_lo | input | 32 | Accumulator low word |
| res_valid | output | 1 | Result bundle is valid |
| dec_ok | output | 1 | Instruction word matched the fixed pattern |
| we_hi | output | 1 | Write enable for the high-word destination |
| we_lo | output | 1 | Write enable for the low-word destination |
| idx_hi | output | 4 | High-word destination register index |
| idx_lo | output | 4 | Low-word destination register index |
| res_hi | output | 32 | New accumulator high word |
| res_lo | output | 32 | New accumulator low word |

## Verification
The assertions check the control side on every cycle:
- the one-cycle valid latency;
- the gating of both writes by the decode pattern and by the condition flag;
- the suppression of the low-word write when the destination indices collide;
- the carrying of the destination indices through the stage.

The arithmetic is covered only by the bench's scenarios, because a property cannot check it without restating the datapath. These scenarios cover:
- all four halfword selections;
- negative and extreme halfwords;
- garbage in the ignored halves;
- sign extension that borrows across the word boundary;
- wrap-around at 2^64.

// File: rtl/hmacl_pkg.sv
package hmacl_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = WORD_W / 2;
  localparam int unsigned ACC_W  = 2 * WORD_W;
  localparam int unsigned IDX_W  = 4;

  typedef struct packed {
    logic              dec_ok;
    logic              we_hi;
    logic              we_lo;
    logic [IDX_W-1:0]  idx_hi;
    logic [IDX_W-1:0]  idx_lo;
    logic [WORD_W-1:0] hi;
    logic [WORD_W-1:0] lo;
  } wb_t;

  // Return the chosen half of a word as a signed value.
  function automatic logic signed [HALF_W-1:0] pick_half(
    input logic [WORD_W-1:0] w, input logic take_top);
    return take_top ? w[WORD_W-1:HALF_W] : w[HALF_W-1:0];
  endfunction

  // Signed halfword product.
  function automatic logic signed [WORD_W-1:0] mul_half(
    input logic signed [HALF_W-1:0] a, input logic signed [HALF_W-1:0] b);
    return WORD_W'(a * b);
  endfunction

  // Sign-extend the product and add it to the accumulator; the sum wraps.
  function automatic logic [ACC_W-1:0] acc_add(
    input logic [ACC_W-1:0] acc, input logic signed [WORD_W-1:0] p);
    logic [ACC_W-1:0] ext;
    ext = {{WORD_W{p[WORD_W-1]}}, p};
    return acc + ext;
  endfunction

endpackage

// File: rtl/hmacl_decode.sv
module hmacl_decode
  import hmacl_pkg::*;
#(
  parameter int unsigned IW = WORD_W,
  parameter int unsigned IXW = IDX_W
) (
  input  logic [IW-1:0]  instr,
  output logic           ok,
  output logic           n_top,
  output logic           m_top,
  output logic [IXW-1:0] hi_idx,
  output logic [IXW-1:0] lo_idx
);
  localparam logic [7:0] FIXED_OP = 8'h14;
  localparam int unsigned HI_LSB = 16;
  localparam int unsigned LO_LSB = 12;

  always_comb begin
    ok     = (instr[27:20] == FIXED_OP) && instr[7] && !instr[4];
    n_top  = instr[5];
    m_top  = instr[6];
    hi_idx = instr[HI_LSB +: IXW];
    lo_idx = instr[LO_LSB +: IXW];
  end
endmodule

// File: rtl/hmacl_datapath.sv
module hmacl_datapath
  import hmacl_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         [W-1:0] src_n,
  input  logic         [W-1:0] src_m,
  input  logic                 n_top,
  input  logic                 m_top,
  input  logic         [W-1:0] acc_hi,
  input  logic         [W-1:0] acc_lo,
  output logic signed  [W-1:0] prod,
  output logic         [W-1:0] sum_hi,
  output logic         [W-1:0] sum_lo
);
  localparam int unsigned NOPS = 2;

  logic        [W-1:0]   srcs [NOPS];
  logic                  tops [NOPS];
  logic signed [W/2-1:0] half [NOPS];
  logic        [2*W-1:0] sum;

  assign srcs[0] = src_n;
  assign srcs[1] = src_m;
  assign tops[0] = n_top;
  assign tops[1] = m_top;

  for (genvar g = 0; g < NOPS; g++) begin : g_sel
    assign half[g] = pick_half(srcs[g], tops[g]);
  end

  always_comb begin
    prod   = mul_half(half[0], half[1]);
    sum    = acc_add({acc_hi, acc_lo}, prod);
    sum_hi = sum[2*W-1:W];
    sum_lo = sum[W-1:0];
  end
endmodule

// File: rtl/hmacl_stage.sv
module hmacl_stage
  import hmacl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  wb_t  d,
  output logic out_valid,
  output wb_t  q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      q         <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) q <= d;
      else begin
        q.we_hi <= 1'b0;
        q.we_lo <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hmacl_unit.sv
module hmacl_unit
  import hmacl_pkg::*;
#(
  parameter int unsigned W   = WORD_W,
  parameter int unsigned IXW = IDX_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [W-1:0]   instr,
  input  logic           cond_pass,
  input  logic [W-1:0]   src_n,
  input  logic [W-1:0]   src_m,
  input  logic [W-1:0]   acc_hi,
  input  logic [W-1:0]   acc_lo,
  output logic           res_valid,
  output logic           dec_ok,
  output logic           we_hi,
  output logic           we_lo,
  output logic [IXW-1:0] idx_hi,
  output logic [IXW-1:0] idx_lo,
  output logic [W-1:0]   res_hi,
  output logic [W-1:0]   res_lo
);
  logic           d_ok, d_n_top, d_m_top;
  logic [IXW-1:0] d_hi_idx, d_lo_idx;
  logic signed [W-1:0] prod;
  logic [W-1:0]   sum_hi, sum_lo;

  // Named events for the checker.
  logic wr_commit;
  logic idx_collide;
  wb_t  wb_d, wb_q;

  hmacl_decode #(.IW(W), .IXW(IXW)) u_dec (
    .instr (instr),
    .ok    (d_ok),
    .n_top (d_n_top),
    .m_top (d_m_top),
    .hi_idx(d_hi_idx),
    .lo_idx(d_lo_idx)
  );

  hmacl_datapath #(.W(W)) u_dp (
    .src_n (src_n),
    .src_m (src_m),
    .n_top (d_n_top),
    .m_top (d_m_top),
    .acc_hi(acc_hi),
    .acc_lo(acc_lo),
    .prod  (prod),
    .sum_hi(sum_hi),
    .sum_lo(sum_lo)
  );

  assign wr_commit   = in_valid && d_ok && cond_pass;
  assign idx_collide = (d_hi_idx == d_lo_idx);

  always_comb begin
    wb_d.dec_ok = d_ok;
    wb_d.we_hi  = wr_commit;
    wb_d.we_lo  = wr_commit && !idx_collide;
    wb_d.idx_hi = d_hi_idx;
    wb_d.idx_lo = d_lo_idx;
    wb_d.hi     = sum_hi;
    wb_d.lo     = sum_lo;
  end

  hmacl_stage u_stage (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .d        (wb_d),
    .out_valid(res_valid),
    .q        (wb_q)
  );

  assign dec_ok = wb_q.dec_ok;
  assign we_hi  = wb_q.we_hi;
  assign we_lo  = wb_q.we_lo;
  assign idx_hi = wb_q.idx_hi;
  assign idx_lo = wb_q.idx_lo;
  assign res_hi = wb_q.hi;
  assign res_lo = wb_q.lo;
endmodule

// File: rtl/hmacl_checker.sv
module hmacl_checker (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [31:0] instr,
  input logic        cond_pass,
  input logic        idx_collide,
  input logic        res_valid,
  input logic        dec_ok,
  input logic        we_hi,
  input logic        we_lo,
  input logic [3:0]  idx_hi,
  input logic [3:0]  idx_lo
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);  // R7
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid && !we_hi && !we_lo);  // R7
  AST_PATTERN_GATE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (instr[27:20] != 8'h14 || !instr[7] || instr[4]))
      |=> !dec_ok && !we_hi && !we_lo);  // R5
  AST_COND_GATE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cond_pass) |=> !we_hi && !we_lo);  // R6
  AST_COLLIDE_HI_ONLY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && idx_collide) |=> !we_lo);  // R9
  AST_LO_NEEDS_HI: assert property (@(posedge clk) disable iff (rst)
    we_lo |-> we_hi && (idx_hi != idx_lo));  // R9
  AST_IDX_CARRY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> idx_hi == $past(instr[19:16]) && idx_lo == $past(instr[15:12]));  // R8
endmodule

bind hmacl_unit hmacl_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .instr      (instr),
  .cond_pass  (cond_pass),
  .idx_collide(idx_collide),
  .res_valid  (res_valid),
  .dec_ok     (dec_ok),
  .we_hi      (we_hi),
  .we_lo      (we_lo),
  .idx_hi     (idx_hi),
  .idx_lo     (idx_lo)
);

// File: tb/test_hmacl_unit.sv
module test_hmacl_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic        cond_pass = 1'b0;
  logic [31:0] src_n = '0, src_m = '0, acc_hi = '0, acc_lo = '0;
  logic        res_valid, dec_ok, we_hi, we_lo;
  logic [3:0]  idx_hi, idx_lo;
  logic [31:0] res_hi, res_lo;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    string       tag;
    logic        ok, whi, wlo;
    logic [3:0]  ihi, ilo;
    logic [63:0] sum;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;  // 50 MHz

  hmacl_unit i_hmacl_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .cond_pass(cond_pass), .src_n(src_n), .src_m(src_m),
    .acc_hi(acc_hi), .acc_lo(acc_lo), .res_valid(res_valid),
    .dec_ok(dec_ok), .we_hi(we_hi), .we_lo(we_lo), .idx_hi(idx_hi),
    .idx_lo(idx_lo), .res_hi(res_hi), .res_lo(res_lo)
  );

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(logic [3:0] hi, logic [3:0] lo,
                                    logic m_top, logic n_top);
    return {4'hE, 8'h14, hi, lo, 4'h3, 1'b1, m_top, n_top, 1'b0, 4'h2};
  endfunction

  // Driver: apply one bundle and queue its expected result.
  task automatic send(string tag, logic [31:0] iw, logic cp, logic [31:0] n,
                      logic [31:0] m, logic [63:0] acc);
    exp_t e;
    longint a, b;
    @(negedge clk);
    in_valid = 1'b1; instr = iw; cond_pass = cp;
    src_n = n; src_m = m; {acc_hi, acc_lo} = acc;
    a = iw[5] ? longint'($signed(n[31:16])) : longint'($signed(n[15:0]));
    b = iw[6] ? longint'($signed(m[31:16])) : longint'($signed(m[15:0]));
    e.tag = tag;
    e.ok  = (iw[27:20] == 8'h14) && iw[7] && !iw[4];
    e.whi = e.ok && cp;
    e.wlo = e.whi && (iw[19:16] != iw[15:12]);
    e.ihi = iw[19:16];
    e.ilo = iw[15:12];
    e.sum = acc + 64'(a * b);
    q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      instr = $urandom; src_n = $urandom; src_m = $urandom;
    end
  endtask

  // Monitor: compare every produced result with the oldest expected item.
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (q.size() == 0) check("R7", "unexpected res_valid", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        check("R5", {e.tag, " dec_ok"}, dec_ok, e.ok);
        check("R6", {e.tag, " we_hi"}, we_hi, e.whi);
        check("R9", {e.tag, " we_lo"}, we_lo, e.wlo);
        check("R8", {e.tag, " idx"}, {idx_hi, idx_lo}, {e.ihi, e.ilo});
        check("R3", {e.tag, " sum"}, {res_hi, res_lo}, e.sum);
      end
    end else if (!rst && (we_hi || we_lo)) begin
      check("R7", "write without valid", 1, 0);
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7", "reset res_valid", res_valid, 0);
    check("R7", "reset we", {we_hi, we_lo}, 0);
    @(negedge clk); rst = 1'b0;

    // R1/R2: four halfword forms with signed operands
    send("R1 BB", mk(4'd1, 4'd0, 0, 0), 1, 32'h7FFF_0003, 32'h1234_FFFE, 64'd100);
    send("R1 TB", mk(4'd1, 4'd0, 0, 1), 1, 32'h7FFF_0003, 32'h1234_FFFE, 64'd100);
    send("R1 BT", mk(4'd1, 4'd0, 1, 0), 1, 32'h7FFF_0003, 32'h1234_FFFE, 64'd100);
    send("R1 TT", mk(4'd1, 4'd0, 1, 1), 1, 32'h7FFF_0003, 32'h1234_FFFE, 64'd100);
    send("R2 min*min", mk(4'd5, 4'd6, 1, 1), 1, 32'h8000_0000, 32'h8000_0000, 64'd0);
    send("R2 neg*pos", mk(4'd5, 4'd6, 0, 0), 1, 32'h0000_8000, 32'h0000_7FFF, 64'd0);
    // R3: negative product borrows across the word boundary
    send("R3 borrow", mk(4'd2, 4'd3, 0, 0), 1, 32'h0000_FFFF, 32'h0000_0001,
         64'h0000_0001_0000_0000);
    // R4: wraps at 2^64 in both directions
    send("R4 wrap up", mk(4'd2, 4'd3, 0, 0), 1, 32'h0000_0002, 32'h0000_0003,
         64'hFFFF_FFFF_FFFF_FFFE);
    send("R4 wrap down", mk(4'd2, 4'd3, 0, 0), 1, 32'h0000_FFFF, 32'h0000_0001, 64'd0);
    // R10: ignored halves full of garbage
    send("R10 ignored", mk(4'd7, 4'd8, 1, 0), 1, 32'hDEAD_0005, 32'h0004_BEEF, 64'd9);
    send("R10 ignored2", mk(4'd7, 4'd8, 1, 0), 1, 32'h1111_0005, 32'h0004_2222, 64'd9);
    // R5: words that break the fixed pattern
    send("R5 op", mk(4'd1, 4'd0, 0, 0) ^ 32'h0010_0000, 1, 32'd3, 32'd3, 64'd1);
    send("R5 bit7", mk(4'd1, 4'd0, 0, 0) & ~32'h80, 1, 32'd3, 32'd3, 64'd1);
    send("R5 bit4", mk(4'd1, 4'd0, 0, 0) | 32'h10, 1, 32'd3, 32'd3, 64'd1);
    // R6: condition failed
    send("R6 cond", mk(4'd4, 4'd9, 1, 1), 0, 32'h0002_0000, 32'h0002_0000, 64'd5);
    // R9: equal destinations
    send("R9 same", mk(4'd11, 4'd11, 0, 0), 1, 32'd6, 32'd7, 64'd1);
    // R7: gaps between issues
    idle(3);
    send("R7 after gap", mk(4'd12, 4'd13, 0, 1), 1, 32'hFFFF_0000, 32'h0000_FFFF, 64'd0);
    idle(1);
    send("R8 idx", mk(4'd15, 4'd14, 1, 0), 1, 32'd1, 32'h0001_0000, 64'd0);
    for (int i = 0; i < 40; i++) begin
      logic [31:0] w;
      w = mk(4'($urandom), 4'($urandom), 1'($urandom), 1'($urandom));
      send("R3 random", w, 1'($urandom), $urandom, $urandom, {$urandom, $urandom});
      if (i % 5 == 0) idle(1);
    end
    idle(4);
    check("R7", "queue drained", q.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule